// File: doc/BRIEF.md
# Counted Push-Down List Controller

This block runs the stack operations of a word-addressed processor. It holds a stack pointer and a two-half limit counter. The upper half of the counter records how many words are on the list, and the lower half records how many more words it can take. A requester gives an operation code, an effective address, the current program counter and the link register, then pulses `start`. The block then makes the word reads and writes it needs over a simple request/ready memory port. At the end it updates the pointer and the counter. For the call and return forms it also returns a new program counter and, where the operation calls for it, a new link value.

A check before any memory traffic guards every operation. If a push needs more free slots than the lower half holds, or a pop needs more stored words than the upper half holds, the operation is refused. The block pulses `trap` and sets a sticky error flag, which stands for bit 3 of the processor status word. It touches nothing else. The two-word operations, call with link save (3) and return with link restore (7), are checked as a whole, so a list with one word or one free slot left refuses them outright. Choosing the register set and forming the effective address are the surrounding pipeline's work.

Top module: `pdl_ctrl`

## Requirements
- R1: After reset `ptr_o` equals PTR_BASE. The upper half of `cnt_o` (bits 2*CNT_W-1:CNT_W, the stored-word count) is 0, and the lower half (bits CNT_W-1:0, the free-slot count) equals FREE_INIT. `busy`, `done`, `trap`, `pdl_err` and `mem_req` are low.
- R2: A push-type operation (op bit 2 = 0) writes its words starting at the pointer. The pointer advances by the item count, which is 2 for op 3 and 1 for the others. The upper counter half rises by the item count and the lower half falls by it.
- R3: A pop-type operation (op bit 2 = 1) reads at pointer-1, and op 7 also reads at pointer-2. The pointer falls by the item count. The upper counter half falls by the item count and the lower half rises by it.
- R4: Op 0 (push without store) and op 4 (pop without read) change the pointer and the counter as R2 and R3 describe, and make no memory access.
- R5: Op 1 reads the word at `ea` and stores that word at the pointer.
- R6: Op 2 stores `pc_in` at the pointer and returns `pc_out` = `ea`. Op 3 stores `link_in` at the pointer and `pc_in` at pointer+1, then returns `link_out` = `pc_in` and `pc_out` = `ea`. Each returned value comes with a one-cycle `pc_we` or `link_we` pulse that coincides with `done`.
- R7: Op 5 copies the word at pointer-1 to address `ea`. Op 6 returns `pc_out` = `ea` (zero-extended) plus the word at pointer-1.
- R8: Op 7 returns `pc_out` = `ea` plus the word at pointer-1, and `link_out` = the word at pointer-2.
- R9: A push needing more slots than the free count, or a pop needing more words than the stored count, gives a one-cycle `trap` in the cycle after `start`. It also sets `pdl_err`, which stays set until reset. The operation makes no memory access, leaves the pointer and the counter unchanged, and gives no `done`, `pc_we` or `link_we`.
- R10: Every access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_rdy` is seen. The number of handshakes per operation is fixed: op 1 takes 2, op 2 takes 1, op 3 takes 2, op 5 takes 2, op 6 takes 1 and op 7 takes 2.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation on `op` |
| op | input | 3 | Operation code 0..7 |
| ea | input | ADDR_W | Effective address |
| pc_in | input | DATA_W | Current program counter |
| link_in | input | DATA_W | Current link register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completed (pulse) |
| trap | output | 1 | Limit violation (pulse) |
| pdl_err | output | 1 | Sticky list error status bit |
| ptr_o | output | ADDR_W | Stack pointer |
| cnt_o | output | 2*CNT_W | {stored count, free count} |
| pc_out | output | DATA_W | New program counter |
| pc_we | output | 1 | `pc_out` valid (pulse) |
| link_out | output | DATA_W | New link value |
| link_we | output | 1 | `link_out` valid (pulse) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Access completes this cycle |

## Verification
The hardest case to reach is a two-word operation when the list sits exactly one word from either limit. There, the first half of the operation would pass and only the second would fail. Reaching it also needs the memory to stall between the two accesses. The bench sets the list level by issuing only push-without-store and pop-without-read operations, which cost no memory traffic. It does this for every level from empty to full in a small four-slot configuration. At each level it issues every operation code. It runs the full sweep twice: once with memory that is always ready, and once with a pseudo-random ready pattern that inserts wait states.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  typedef enum logic [2:0] {
    PD_PUSH_NIL  = 3'd0,
    PD_PUSH_MEM  = 3'd1,
    PD_CALL      = 3'd2,
    PD_CALL_LINK = 3'd3,
    PD_POP_NIL   = 3'd4,
    PD_POP_MEM   = 3'd5,
    PD_RET       = 3'd6,
    PD_RET_LINK  = 3'd7
  } pd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WR_A,
    ST_WR_B,
    ST_RD_A,
    ST_RD_B,
    ST_STORE,
    ST_DONE
  } pd_state_e;

  // number of list words an operation moves
  function automatic logic [1:0] op_items(pd_op_e o);
    return (o == PD_CALL_LINK || o == PD_RET_LINK) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic op_is_pop(pd_op_e o);
    return o inside {PD_POP_NIL, PD_POP_MEM, PD_RET, PD_RET_LINK};
  endfunction

  function automatic logic st_is_mem(pd_state_e s);
    return s inside {ST_FETCH, ST_WR_A, ST_WR_B, ST_RD_A, ST_RD_B, ST_STORE};
  endfunction

  function automatic logic st_is_write(pd_state_e s);
    return s inside {ST_WR_A, ST_WR_B, ST_STORE};
  endfunction

endpackage

// File: rtl/pdl_limit.sv
module pdl_limit
  import pdl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  pd_op_e           op,
  input  logic [CNT_W-1:0] used,
  input  logic [CNT_W-1:0] free,
  output logic             fault,
  output logic [CNT_W-1:0] used_nx,
  output logic [CNT_W-1:0] free_nx
);

  logic [CNT_W-1:0] n;
  logic             pop;

  assign n   = CNT_W'(op_items(op));
  assign pop = op_is_pop(op);

  // a half that would be decremented below zero refuses the whole operation
  always_comb begin
    if (pop) begin
      fault   = (used < n);
      used_nx = used - n;
      free_nx = free + n;
    end else begin
      fault   = (free < n);
      used_nx = used + n;
      free_nx = free - n;
    end
  end

endmodule

// File: rtl/pdl_addr.sv
module pdl_addr
  import pdl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  pd_state_e         st,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    unique case (st)
      ST_WR_A:            addr = ptr;
      ST_WR_B:            addr = ptr + ADDR_W'(1);
      ST_RD_A:            addr = ptr - ADDR_W'(1);
      ST_RD_B:            addr = ptr - ADDR_W'(2);
      ST_FETCH, ST_STORE: addr = ea;
      default:            addr = '0;
    endcase
  end

endmodule

// File: rtl/pdl_result.sv
module pdl_result
  import pdl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  pd_op_e            op,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] rd0,
  input  logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] pc_val,
  output logic              pc_wr,
  output logic [DATA_W-1:0] link_val,
  output logic              link_wr
);

  logic [DATA_W-1:0] ea_x;
  assign ea_x = DATA_W'(ea);

  always_comb begin
    pc_val   = '0;
    pc_wr    = 1'b0;
    link_val = '0;
    link_wr  = 1'b0;
    unique case (op)
      PD_CALL: begin
        pc_val = ea_x;
        pc_wr  = 1'b1;
      end
      PD_CALL_LINK: begin
        pc_val   = ea_x;
        pc_wr    = 1'b1;
        link_val = pc;
        link_wr  = 1'b1;
      end
      PD_RET: begin
        pc_val = ea_x + rd0;
        pc_wr  = 1'b1;
      end
      PD_RET_LINK: begin
        pc_val   = ea_x + rd0;
        pc_wr    = 1'b1;
        link_val = rd1;
        link_wr  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pdl_ctrl.sv
module pdl_ctrl
  import pdl_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 16,
  parameter int                CNT_W     = 8,
  parameter logic [ADDR_W-1:0] PTR_BASE  = '0,
  parameter int unsigned       FREE_INIT = 255
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2:0]           op,
  input  logic [ADDR_W-1:0]    ea,
  input  logic [DATA_W-1:0]    pc_in,
  input  logic [DATA_W-1:0]    link_in,
  output logic                 busy,
  output logic                 done,
  output logic                 trap,
  output logic                 pdl_err,
  output logic [ADDR_W-1:0]    ptr_o,
  output logic [2*CNT_W-1:0]   cnt_o,
  output logic [DATA_W-1:0]    pc_out,
  output logic                 pc_we,
  output logic [DATA_W-1:0]    link_out,
  output logic                 link_we,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_rdy
);

  localparam logic [CNT_W-1:0] FREE_RST = CNT_W'(FREE_INIT);

  pd_state_e         state_q, state_n;
  pd_op_e            op_q, cur_op;
  logic [ADDR_W-1:0] ea_q, cur_ea, ptr_q, addr_n, step;
  logic [DATA_W-1:0] pc_q, link_q, cur_pc, cur_link;
  logic [DATA_W-1:0] rd0_q, rd1_q, rd0_n, rd1_n, wdata_n;
  logic [CNT_W-1:0]  used_q, free_q, used_nx, free_nx;
  logic [DATA_W-1:0] pc_val, link_val;
  logic              pc_wr, link_wr;
  logic              idle, fault, hs, accept, refuse;

  assign idle     = (state_q == ST_IDLE);
  assign cur_op   = idle ? pd_op_e'(op) : op_q;
  assign cur_ea   = idle ? ea      : ea_q;
  assign cur_pc   = idle ? pc_in   : pc_q;
  assign cur_link = idle ? link_in : link_q;
  assign hs       = mem_req && mem_rdy;
  assign accept   = idle && start && !fault;
  assign refuse   = idle && start && fault;
  assign step     = ADDR_W'(op_items(op_q));

  pdl_limit #(.CNT_W(CNT_W)) u_limit (
    .op      (cur_op),
    .used    (used_q),
    .free    (free_q),
    .fault   (fault),
    .used_nx (used_nx),
    .free_nx (free_nx)
  );

  pdl_addr #(.ADDR_W(ADDR_W)) u_addr (
    .st   (state_n),
    .ptr  (ptr_q),
    .ea   (cur_ea),
    .addr (addr_n)
  );

  pdl_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_result (
    .op       (op_q),
    .ea       (ea_q),
    .pc       (pc_q),
    .rd0      (rd0_q),
    .rd1      (rd1_q),
    .pc_val   (pc_val),
    .pc_wr    (pc_wr),
    .link_val (link_val),
    .link_wr  (link_wr)
  );

  // sequencing
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (cur_op)
            PD_PUSH_NIL, PD_POP_NIL:        state_n = ST_DONE;
            PD_PUSH_MEM:                    state_n = ST_FETCH;
            PD_CALL, PD_CALL_LINK:          state_n = ST_WR_A;
            default:                        state_n = ST_RD_A;
          endcase
        end
      end
      ST_FETCH: if (hs) state_n = ST_WR_A;
      ST_WR_A:  if (hs) state_n = (op_q == PD_CALL_LINK) ? ST_WR_B : ST_DONE;
      ST_WR_B:  if (hs) state_n = ST_DONE;
      ST_RD_A: begin
        if (hs) begin
          if (op_q == PD_RET_LINK)     state_n = ST_RD_B;
          else if (op_q == PD_POP_MEM) state_n = ST_STORE;
          else                         state_n = ST_DONE;
        end
      end
      ST_RD_B:  if (hs) state_n = ST_DONE;
      ST_STORE: if (hs) state_n = ST_DONE;
      default:  state_n = ST_IDLE;
    endcase
  end

  // captured read words and next write word
  always_comb begin
    rd0_n = rd0_q;
    if (hs && (state_q == ST_FETCH || state_q == ST_RD_A)) rd0_n = mem_rdata;
    rd1_n = (hs && state_q == ST_RD_B) ? mem_rdata : rd1_q;
    unique case (state_n)
      ST_WR_A: begin
        if (cur_op == PD_PUSH_MEM)  wdata_n = rd0_n;
        else if (cur_op == PD_CALL) wdata_n = cur_pc;
        else                        wdata_n = cur_link;
      end
      ST_WR_B:  wdata_n = cur_pc;
      ST_STORE: wdata_n = rd0_n;
      default:  wdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= PD_PUSH_NIL;
      ea_q      <= '0;
      pc_q      <= '0;
      link_q    <= '0;
      rd0_q     <= '0;
      rd1_q     <= '0;
      ptr_q     <= PTR_BASE;
      used_q    <= '0;
      free_q    <= FREE_RST;
      busy      <= 1'b0;
      done      <= 1'b0;
      trap      <= 1'b0;
      pdl_err   <= 1'b0;
      pc_out    <= '0;
      pc_we     <= 1'b0;
      link_out  <= '0;
      link_we   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state_q   <= state_n;
      busy      <= (state_n != ST_IDLE);
      mem_req   <= st_is_mem(state_n);
      mem_we    <= st_is_write(state_n);
      mem_addr  <= addr_n;
      mem_wdata <= wdata_n;
      rd0_q     <= rd0_n;
      rd1_q     <= rd1_n;
      trap      <= refuse;
      pdl_err   <= pdl_err | refuse;
      done      <= (state_q == ST_DONE);
      pc_we     <= (state_q == ST_DONE) && pc_wr;
      link_we   <= (state_q == ST_DONE) && link_wr;
      if (accept) begin
        op_q   <= cur_op;
        ea_q   <= ea;
        pc_q   <= pc_in;
        link_q <= link_in;
      end
      if (state_q == ST_DONE) begin
        ptr_q  <= op_is_pop(op_q) ? ptr_q - step : ptr_q + step;
        used_q <= used_nx;
        free_q <= free_nx;
        if (pc_wr)   pc_out   <= pc_val;
        if (link_wr) link_out <= link_val;
      end
    end
  end

  assign ptr_o = ptr_q;
  assign cnt_o = {used_q, free_q};

endmodule

// File: rtl/pdl_chk.sv
module pdl_chk #(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 16,
  parameter int                CNT_W     = 8,
  parameter logic [ADDR_W-1:0] PTR_BASE  = '0,
  parameter int unsigned       FREE_INIT = 255
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               trap,
  input logic               pdl_err,
  input logic [ADDR_W-1:0]  ptr_o,
  input logic [2*CNT_W-1:0] cnt_o,
  input logic               pc_we,
  input logic               link_we,
  input logic               mem_req,
  input logic               mem_we,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               mem_rdy
);

  localparam logic [CNT_W:0] CNT_SUM = (CNT_W+1)'(FREE_INIT);

  logic [CNT_W:0]  half_sum;
  logic [ADDR_W-1:0] ptr_from_cnt;

  assign half_sum     = {1'b0, cnt_o[2*CNT_W-1:CNT_W]} + {1'b0, cnt_o[CNT_W-1:0]};
  assign ptr_from_cnt = PTR_BASE + ADDR_W'(cnt_o[2*CNT_W-1:CNT_W]);

  AST_CNT_BALANCE: assert property (@(posedge clk) disable iff (rst)
    half_sum == CNT_SUM);  // R2

  AST_PTR_TRACKS_CNT: assert property (@(posedge clk) disable iff (rst)
    ptr_o == ptr_from_cnt);  // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);  // R11

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R11

  AST_TRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    trap |-> $stable(ptr_o) && $stable(cnt_o) && !busy && !done);  // R9

  AST_TRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    trap |-> pdl_err);  // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    pdl_err |=> pdl_err);  // R9

  AST_WE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (pc_we || link_we) |-> done);  // R6

endmodule

bind pdl_ctrl pdl_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .PTR_BASE  (PTR_BASE),
  .FREE_INIT (FREE_INIT)
) u_pdl_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .trap      (trap),
  .pdl_err   (pdl_err),
  .ptr_o     (ptr_o),
  .cnt_o     (cnt_o),
  .pc_we     (pc_we),
  .link_we   (link_we),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdy   (mem_rdy)
);

// File: tb/tb_pdl_ctrl.sv
module tb_pdl_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int AW    = 8;
  localparam int CW    = 8;
  localparam logic [7:0] BASE = 8'h40;
  localparam int DEPTH = 4;

  logic          clk, rst, start;
  logic [2:0]    op;
  logic [AW-1:0] ea;
  logic [DW-1:0] pc_in, link_in;
  logic          busy, done, trap, pdl_err;
  logic [AW-1:0] ptr_o;
  logic [2*CW-1:0] cnt_o;
  logic [DW-1:0] pc_out, link_out;
  logic          pc_we, link_we;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_rdy;

  pdl_ctrl #(
    .DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .PTR_BASE(BASE), .FREE_INIT(DEPTH)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .ea(ea), .pc_in(pc_in),
    .link_in(link_in), .busy(busy), .done(done), .trap(trap), .pdl_err(pdl_err),
    .ptr_o(ptr_o), .cnt_o(cnt_o), .pc_out(pc_out), .pc_we(pc_we),
    .link_out(link_out), .link_we(link_we), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 257) ^ 16'hA5C3;
  endfunction

  // memory model
  logic [DW-1:0] mem [0:255];
  int hs_cnt;
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < 256; a++) mem[a] <= pat(a);
      hs_cnt <= 0;
    end else if (mem_req && mem_rdy) begin
      hs_cnt <= hs_cnt + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
    end
  end

  // ready generator: always ready, or pseudo-random wait states (R10)
  int         rdy_mode;
  logic [7:0] lfsr = 8'h5B;
  always @(negedge clk) begin
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy <= (rdy_mode == 0) ? 1'b1 : (lfsr[1] | lfsr[4]);
  end

  int errors = 0;
  int checks = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  // model state
  logic [DW-1:0] exp_mem [0:255];
  logic [7:0]    m_ptr;
  int            m_used, m_free;
  bit            m_err;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, expv);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [7:0] e,
                       input logic [15:0] p, input logic [15:0] l, input bit poke);
    int n, xacc, h0, bad, first_bad;
    bit push, xt, xpcw, xlinkw, got_done, got_trap, g_pcw, g_linkw;
    logic [15:0] xpc, xlink, g_pc, g_link;
    string rq;
    n = (o == 3 || o == 7) ? 2 : 1;
    push = !o[2];
    xt = push ? (m_free < n) : (m_used < n);
    xpc = '0; xlink = '0; xpcw = 0; xlinkw = 0; xacc = 0;
    case (o)
      3'd0, 3'd4: rq = "R4";
      3'd1:       rq = "R5";
      3'd2, 3'd3: rq = "R6";
      3'd5, 3'd6: rq = "R7";
      default:    rq = "R8";
    endcase
    if (xt) begin
      rq = "R9";
      m_err = 1;
    end else begin
      case (o)
        3'd0: m_ptr = m_ptr + 8'd1;
        3'd1: begin exp_mem[m_ptr] = exp_mem[e]; m_ptr = m_ptr + 8'd1; xacc = 2; end
        3'd2: begin exp_mem[m_ptr] = p; m_ptr = m_ptr + 8'd1; xpc = {8'h00, e}; xpcw = 1; xacc = 1; end
        3'd3: begin
          exp_mem[m_ptr] = l; exp_mem[8'(m_ptr + 8'd1)] = p; m_ptr = m_ptr + 8'd2;
          xpc = {8'h00, e}; xpcw = 1; xlink = p; xlinkw = 1; xacc = 2;
        end
        3'd4: m_ptr = m_ptr - 8'd1;
        3'd5: begin m_ptr = m_ptr - 8'd1; exp_mem[e] = exp_mem[m_ptr]; xacc = 2; end
        3'd6: begin m_ptr = m_ptr - 8'd1; xpc = {8'h00, e} + exp_mem[m_ptr]; xpcw = 1; xacc = 1; end
        default: begin
          xpc = {8'h00, e} + exp_mem[8'(m_ptr - 8'd1)]; xlink = exp_mem[8'(m_ptr - 8'd2)];
          m_ptr = m_ptr - 8'd2; xpcw = 1; xlinkw = 1; xacc = 2;
        end
      endcase
      if (push) begin m_used += n; m_free -= n; end
      else      begin m_used -= n; m_free += n; end
    end

    @(negedge clk);
    start = 1'b1; op = o; ea = e; pc_in = p; link_in = l;
    h0 = hs_cnt;
    got_done = 0; got_trap = 0; g_pcw = 0; g_linkw = 0; g_pc = '0; g_link = '0;
    for (int c = 0; c < 200; c++) begin
      @(posedge clk); #1;
      if (c == 0 && poke && busy) begin start = 1'b1; op = 3'd0; end
      else start = 1'b0;
      if (trap) got_trap = 1;
      if (done) begin
        got_done = 1; g_pcw = pc_we; g_linkw = link_we; g_pc = pc_out; g_link = link_out;
      end
      if (got_trap || got_done) break;
    end
    start = 1'b0;
    @(negedge clk);

    chk(got_trap == xt, rq, "trap", 32'(got_trap), 32'(xt));
    chk(got_done == !xt, "R11", "done", 32'(got_done), 32'(!xt));
    chk(ptr_o == m_ptr, xt ? "R9" : (push ? "R2" : "R3"), "pointer", 32'(ptr_o), 32'(m_ptr));
    chk(cnt_o == {8'(m_used), 8'(m_free)}, xt ? "R9" : (push ? "R2" : "R3"), "counter",
        32'(cnt_o), 32'({8'(m_used), 8'(m_free)}));
    chk(pdl_err == m_err, "R9", "error flag", 32'(pdl_err), 32'(m_err));
    chk((hs_cnt - h0) == xacc, "R10", "access count", 32'(hs_cnt - h0), 32'(xacc));
    if (poke) chk(!busy, "R11", "busy after poke", 32'(busy), 32'(0));
    if (!xt) begin
      chk(g_pcw == xpcw, rq, "pc_we", 32'(g_pcw), 32'(xpcw));
      chk(g_linkw == xlinkw, rq, "link_we", 32'(g_linkw), 32'(xlinkw));
      if (xpcw)   chk(g_pc == xpc, rq, "pc_out", 32'(g_pc), 32'(xpc));
      if (xlinkw) chk(g_link == xlink, rq, "link_out", 32'(g_link), 32'(xlink));
    end
    bad = 0; first_bad = 0;
    for (int a = 0; a < 256; a++)
      if (mem[a] !== exp_mem[a]) begin
        if (bad == 0) first_bad = a;
        bad++;
      end
    chk(bad == 0, rq, "memory image", 32'(mem[first_bad]), 32'(exp_mem[first_bad]));
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; op = '0; ea = '0; pc_in = '0; link_in = '0; rdy_mode = 0;
    for (int a = 0; a < 256; a++) exp_mem[a] = pat(a);
    m_ptr = BASE; m_used = 0; m_free = DEPTH; m_err = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ptr_o == BASE, "R1", "pointer", 32'(ptr_o), 32'(BASE));
    chk(cnt_o == 16'(DEPTH), "R1", "counter", 32'(cnt_o), 32'(DEPTH));
    chk(!busy && !done && !trap, "R1", "busy/done/trap", 32'({busy, done, trap}), 32'(0));
    chk(!pdl_err, "R1", "error flag", 32'(pdl_err), 32'(0));
    chk(!mem_req, "R1", "mem_req", 32'(mem_req), 32'(0));

    for (int mode = 0; mode < 2; mode++) begin
      rdy_mode = mode;
      for (int tgt = 0; tgt <= DEPTH; tgt++) begin
        for (int o = 0; o < 8; o++) begin
          while (m_used < tgt) do_op(3'd0, 8'h00, 16'h0, 16'h0, 1'b0);
          while (m_used > tgt) do_op(3'd4, 8'h00, 16'h0, 16'h0, 1'b0);
          do_op(3'(o), 8'h90 + 8'(o), 16'h1000 + 16'(tgt * 16 + o + mode * 256),
                16'h2000 + 16'(tgt * 8 + o), (o % 2) == 0);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule